// File: doc/BRIEF.md
# Lock Contention Limiter Tracker

This block watches the lock traffic of one multi-threaded program and picks out the thread most likely to be on the program's critical path. Each lock has a live count of blocked threads, raised by a wait-start event and lowered by a wait-stop event, and an accumulator. Every cycle the accumulator adds that count, so it holds the total thread-cycles spent waiting on the lock since the last interval boundary. Acquire and release events record which thread currently owns each lock.

The interval has a fixed length of `INTERVAL_CYCLES` cycles. At each boundary the block picks the lock with the largest accumulated wait as the most contended lock. The owner of that lock becomes the limiter thread. The limiter is reported to the memory request scheduler as a one-hot thread mask, and the mask then stays fixed for the whole next interval. The accumulators restart from zero for the new interval.

Top module: `lock_limiter_tracker`

## Requirements
- R1: Each lock keeps a count of its blocked threads. A wait-start for the lock adds one and a wait-stop subtracts one, and both take effect at the next rising edge. A start and a stop on the same lock in the same cycle leave the count unchanged. A stop on a zero count is ignored, and so is a start on a count of `N_THREADS`. In every cycle a lock's accumulator adds the count held during that cycle.
- R2: An interval boundary falls on every `INTERVAL_CYCLES`-th rising edge after reset is released. The interval that closes at a boundary covers the `INTERVAL_CYCLES` cycles before that edge, and the boundary cycle itself is included.
- R3: At a boundary, `limiter_mask_o` is loaded with a mask in which only bit t is set, where t is the thread that owns the lock with the largest accumulated wait.
- R4: When two or more locks are equal at the largest wait, the one with the lowest lock index wins.
- R5: When the winning lock has no owner at the boundary, the mask is loaded with zero. The mask does not fall back to another lock.
- R6: When every accumulator is zero at a boundary, the mask is loaded with zero.
- R7: An accumulator saturates at 2^`ACC_W`-1 and never wraps.
- R8: All accumulators restart from zero after each boundary, so no wait carries over from one interval into the next.
- R9: `limiter_mask_o` changes only at boundary edges. Between boundaries it holds its value whatever lock events arrive.
- R10: An acquire sets the lock's owner at the next edge, and a release clears it. When an acquire and a release for the same lock come in the same cycle, the acquire wins. The owner seen at a boundary is the one registered before that edge.
- R11: While reset is asserted, the mask is zero, no lock has an owner, and all counts and accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_start_i | input | 1 | A thread starts waiting on `wait_start_lock_i` |
| wait_start_lock_i | input | $clog2(N_LOCKS) | Lock index for wait-start |
| wait_stop_i | input | 1 | A thread stops waiting on `wait_stop_lock_i` |
| wait_stop_lock_i | input | $clog2(N_LOCKS) | Lock index for wait-stop |
| acquire_i | input | 1 | `acquire_thread_i` takes ownership of `acquire_lock_i` |
| acquire_lock_i | input | $clog2(N_LOCKS) | Lock index for acquire |
| acquire_thread_i | input | $clog2(N_THREADS) | Thread index for acquire |
| release_i | input | 1 | The owner of `release_lock_i` gives it up |
| release_lock_i | input | $clog2(N_LOCKS) | Lock index for release |
| limiter_mask_o | output | N_THREADS | One-hot limiter thread (bit t = thread t), or zero |

## Verification
A lock event changes that lock's count at the first rising edge after it is driven. From then on the count is added on every edge, so a single waiter that starts in cycle p of an interval adds `INTERVAL_CYCLES`-1-p to that interval's sum. The mask is loaded on the boundary edge and is read at the falling edge that follows. The bench counts rising edges from the release of reset, so it knows the phase of the interval without looking inside the design. It drives every event at a falling edge and computes each expected winner by hand from these phase counts. The bench also samples the mask just before a boundary and in the middle of an interval to confirm that the mask holds between boundaries.

// File: rtl/lock_lim_pkg.sv
`timescale 1ns/1ps
package lock_lim_pkg;
  localparam int unsigned DEF_THREADS  = 8;
  localparam int unsigned DEF_LOCKS    = 4;
  localparam int unsigned DEF_ACC_W    = 20;
  localparam int unsigned DEF_INTERVAL = 1024;
endpackage

// File: rtl/lock_lim_timer.sv
`timescale 1ns/1ps
module lock_lim_timer #(
  parameter int unsigned INTERVAL_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bnd_o
);
  localparam int unsigned CNT_W = (INTERVAL_CYCLES > 2) ? $clog2(INTERVAL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign bnd_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (bnd_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R2: boundaries never come back to back
  a_r2_bnd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_o |=> !bnd_o);
endmodule

// File: rtl/lock_lim_slot.sv
`timescale 1ns/1ps
module lock_lim_slot #(
  parameter int unsigned N_THREADS = 8,
  parameter int unsigned ACC_W     = 20,
  localparam int unsigned CNT_W    = $clog2(N_THREADS + 1),
  localparam int unsigned TW       = $clog2(N_THREADS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             acq_i,
  input  logic [TW-1:0]    acq_thread_i,
  input  logic             rel_i,
  output logic [ACC_W-1:0] acc_nxt_o,
  output logic             owner_vld_o,
  output logic [TW-1:0]    owner_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(N_THREADS);

  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  // waiter count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // saturating accumulate, this cycle's waiters included
  assign sum       = {1'b0, acc_q} + (ACC_W+1)'(cnt_q);
  assign acc_nxt_o = sum[ACC_W] ? '1 : sum[ACC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= acc_nxt_o;
  end

  // owner; acquire beats release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_vld_o <= 1'b0;
      owner_o     <= '0;
    end else if (acq_i) begin
      owner_vld_o <= 1'b1;
      owner_o     <= acq_thread_i;
    end else if (rel_i) begin
      owner_vld_o <= 1'b0;
    end
  end

  a_r1_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)
             || (cnt_q + 1'b1 == $past(cnt_q)));

  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  a_r7_acc_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/lock_lim_select.sv
`timescale 1ns/1ps
module lock_lim_select #(
  parameter int unsigned N_LOCKS = 4,
  parameter int unsigned ACC_W   = 20,
  localparam int unsigned LW     = $clog2(N_LOCKS)
) (
  input  logic [N_LOCKS-1:0][ACC_W-1:0] acc_i,
  output logic [LW-1:0]                 win_o,
  output logic [ACC_W-1:0]              win_val_o
);
  // linear scan; strict compare keeps the lowest index on ties
  always_comb begin
    win_o     = '0;
    win_val_o = acc_i[0];
    for (int i = 1; i < int'(N_LOCKS); i++) begin
      if (acc_i[i] > win_val_o) begin
        win_o     = LW'(i);
        win_val_o = acc_i[i];
      end
    end
  end
endmodule

// File: rtl/lock_limiter_tracker.sv
`timescale 1ns/1ps
module lock_limiter_tracker
  import lock_lim_pkg::*;
#(
  parameter int unsigned N_THREADS       = DEF_THREADS,
  parameter int unsigned N_LOCKS         = DEF_LOCKS,
  parameter int unsigned ACC_W           = DEF_ACC_W,
  parameter int unsigned INTERVAL_CYCLES = DEF_INTERVAL,
  localparam int unsigned LW             = $clog2(N_LOCKS),
  localparam int unsigned TW             = $clog2(N_THREADS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wait_start_i,
  input  logic [LW-1:0]        wait_start_lock_i,
  input  logic                 wait_stop_i,
  input  logic [LW-1:0]        wait_stop_lock_i,
  input  logic                 acquire_i,
  input  logic [LW-1:0]        acquire_lock_i,
  input  logic [TW-1:0]        acquire_thread_i,
  input  logic                 release_i,
  input  logic [LW-1:0]        release_lock_i,
  output logic [N_THREADS-1:0] limiter_mask_o
);
  logic                          bnd;
  logic [N_LOCKS-1:0][ACC_W-1:0] acc_nxt;
  logic [N_LOCKS-1:0]            owner_vld;
  logic [N_LOCKS-1:0][TW-1:0]    owner;
  logic [LW-1:0]                 win;
  logic [ACC_W-1:0]              win_val;
  logic [N_THREADS-1:0]          mask_nxt;

  lock_lim_timer #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bnd_o (bnd)
  );

  for (genvar g = 0; g < int'(N_LOCKS); g++) begin : g_slot
    lock_lim_slot #(.N_THREADS(N_THREADS), .ACC_W(ACC_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (bnd),
      .inc_i       (wait_start_i && (wait_start_lock_i == LW'(g))),
      .dec_i       (wait_stop_i  && (wait_stop_lock_i  == LW'(g))),
      .acq_i       (acquire_i    && (acquire_lock_i    == LW'(g))),
      .acq_thread_i(acquire_thread_i),
      .rel_i       (release_i    && (release_lock_i    == LW'(g))),
      .acc_nxt_o   (acc_nxt[g]),
      .owner_vld_o (owner_vld[g]),
      .owner_o     (owner[g])
    );
  end

  lock_lim_select #(.N_LOCKS(N_LOCKS), .ACC_W(ACC_W)) u_select (
    .acc_i    (acc_nxt),
    .win_o    (win),
    .win_val_o(win_val)
  );

  always_comb begin
    mask_nxt = '0;
    if ((win_val != '0) && owner_vld[win]) mask_nxt[owner[win]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  limiter_mask_o <= '0;
    else if (bnd) limiter_mask_o <= mask_nxt;
  end

  a_r3_mask_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(limiter_mask_o));

  a_r9_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd |=> $stable(limiter_mask_o));
endmodule

// File: tb/lock_limiter_tracker_bench.sv
`timescale 1ns/1ps
module lock_limiter_tracker_bench;
  localparam int NT = 8;
  localparam int NL = 4;
  localparam int IV = 16;
  localparam int AW = 6;   // saturates at 63

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wb = 0, we = 0, aq = 0, rl = 0;
  logic [1:0] wb_l = 0, we_l = 0, aq_l = 0, rl_l = 0;
  logic [2:0] aq_t = 0;
  logic [NT-1:0] mask;

  int n_chk = 0, n_fail = 0, ec = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  always @(posedge clk_i) if (rst_ni) ec <= ec + 1;

  lock_limiter_tracker #(.N_THREADS(NT), .N_LOCKS(NL), .ACC_W(AW), .INTERVAL_CYCLES(IV))
  u_lock_limiter_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wait_start_i(wb), .wait_start_lock_i(wb_l),
    .wait_stop_i(we), .wait_stop_lock_i(we_l),
    .acquire_i(aq), .acquire_lock_i(aq_l), .acquire_thread_i(aq_t),
    .release_i(rl), .release_lock_i(rl_l),
    .limiter_mask_o(mask)
  );

  task automatic chk(input string req, input logic [NT-1:0] act, input logic [NT-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: limiter_mask_o=%b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    wb = 0; we = 0; aq = 0; rl = 0;
  endtask

  task automatic go_phase(input int p);
    while (ec % IV != p) tick();
  endtask

  task automatic go_start();
    tick();
    go_phase(0);
  endtask

  task automatic ev_start(input int l); wb = 1; wb_l = 2'(l); endtask
  task automatic ev_stop (input int l); we = 1; we_l = 2'(l); endtask
  task automatic ev_acq(input int l, input int t); aq = 1; aq_l = 2'(l); aq_t = 3'(t); endtask
  task automatic ev_rel(input int l); rl = 1; rl_l = 2'(l); endtask

  // R11: reset state
  task automatic t_reset();
    chk("R11 reset mask", mask, '0);
  endtask

  // R6: owner present but no waiting at all
  task automatic t_idle();
    go_phase(0);
    ev_acq(0, 2); tick();
    go_start();
    chk("R6 all sums zero", mask, '0);
  endtask

  // R5, R10: winner lock released before boundary
  task automatic t_no_owner();
    ev_acq(1, 3); ev_start(1); tick();
    ev_rel(1);    ev_start(1); tick();   // lock1 = 15+14 = 29
    ev_start(0);  tick();                // lock0 = 13, owned by t2
    go_phase(IV-1);
    chk("R9 before boundary", mask, '0);
    go_start();
    chk("R5 R10 winner unowned", mask, '0);
    ev_stop(1); tick(); ev_stop(1); tick(); ev_stop(0); tick();
  endtask

  // R1, R2, R3, R9: basic pick, then hold mid-interval
  task automatic t_basic();
    go_start();
    ev_acq(2, 5); ev_start(2); tick();
    ev_acq(1, 3); ev_start(2); tick();   // lock2 = 29
    ev_start(1);  tick();                // lock1 = 13
    go_start();
    chk("R1 R2 R3 largest wait owner", mask, 8'b0010_0000);
    ev_stop(2); tick(); ev_stop(2); tick(); ev_stop(1); tick();
    go_phase(8);
    chk("R9 hold mid interval", mask, 8'b0010_0000);
  endtask

  // R4: equal sums, lowest lock wins
  task automatic t_tie();
    go_start();
    ev_acq(3, 6); ev_start(3); tick();   // lock3 15
    ev_start(0); tick();                 // lock0 14
    ev_start(0); tick();                 // lock0 13
    ev_start(3); tick();                 // lock3 12 -> both 27
    go_start();
    chk("R4 tie lowest lock", mask, 8'b0000_0100);
    ev_stop(3); tick(); ev_stop(0); tick(); ev_stop(0); tick(); ev_stop(3); tick();
    go_phase(12);
    chk("R9 hold after tie", mask, 8'b0000_0100);
  endtask

  // R7, R8, R1: saturation, then clearing
  task automatic t_sat_clear();
    go_start();
    for (int i = 0; i < 11; i++) begin
      if (i == 0) ev_acq(3, 7);
      if (i == 1) ev_acq(1, 4);
      ev_start(i < 8 ? 3 : 1);
      tick();
    end
    go_start();   // lock3 92->63, lock1 18
    chk("R7 first saturating interval", mask, 8'b1000_0000);
    go_start();   // lock3 128->63, lock1 48; wrapping would give 0 vs 48
    chk("R7 saturate not wrap", mask, 8'b1000_0000);
    for (int i = 0; i < 11; i++) begin
      ev_stop(i < 8 ? 3 : 1);
      tick();
    end
    go_start();   // lock3 36, lock1 30
    chk("R1 draining counts", mask, 8'b1000_0000);
    ev_acq(2, 0); ev_start(2); tick();   // lock2 15, others 0
    go_start();
    chk("R8 sums cleared at boundary", mask, 8'b0000_0001);
    ev_stop(2); tick();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_idle();
    t_no_owner();
    t_basic();
    t_tie();
    t_sat_clear();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule